// File: doc/BRIEF.md
# Buck Converter Fault Supervisor

This block watches a synchronous buck controller and decides, one switching cycle at a time, whether the high-side switch may fire and whether the converter must be shut down. It takes a one-clock cycle-start strobe from the PWM oscillator and a set of comparator bits: current limit, feedback under-voltage, feedback over-voltage, high-side fault, feedback near ground, and three output-level thresholds at 0.5 V, 0.8 V and 1 V. It also takes a soft-start flag that is high while the soft-start node is still below 1.5 V, plus the enable and a power-on reset.

An overcurrent event does not trip the converter at once. The first event starts a pulse-skip window. Only a second event later in that window sets the fault latch. Under-voltage is filtered over a fixed time in clock cycles. Over-voltage is filtered over a count of consecutive switching cycles. A high-side fault, or a feedback pin that reads near ground while the output is above 1 V, sets the latch at once.

While the latch is set, the block pulses the low-side switch between the two output thresholds, so the output is pulled down without going negative. A discharge load is switched in whenever the latch is set or the enable is low.

Top module: `buck_fault_supervisor`

## Requirements
- R1: A current-limit bit that is high on a cycle-start clock while no skip window is open opens a skip window. `hs_inhibit` is high from the following clock until the ninth later cycle start, so the detecting cycle and the next 8 cycles are skipped.
- R2: Cycles 9 to 16 after the detecting cycle form the trip window. A current-limit bit high at the start of any of these cycles sets `fault_latched` on the next clock. If no recurrence happens, the window closes at the start of cycle 17 with no fault.
- R3: `fb_uv` high for 500 consecutive clocks (2 µs at 250 MHz) sets the latch. Any clock with `fb_uv` low restarts the count, so 499 clocks do not set it.
- R4: `fb_ov` held high across 16 consecutive cycle starts sets the latch. Dropping it on any clock restarts the count, so 15 cycle starts do not set it.
- R5: While `ss_low` is high, neither an overcurrent recurrence nor any length of under-voltage sets the latch.
- R6: Over-voltage, `hs_fault`, and shorted feedback (`out_gt_1v0` and `fb_lt_100m` both high) set the latch even while `ss_low` is high. The last two act on the next clock.
- R7: While latched, `ls_force` is high on entry. It goes low the clock after `out_lt_0p5` is seen, and high again the clock after `out_gt_0p8` is seen. It is never high while the latch is clear.
- R8: `dis_load` is high exactly when the latch is set or `en` is low.
- R9: The latch clears only on reset or on a clock where `en` is low, and it stays clear while `en` is low. After reset all four outputs are low.
- R10: While the latch is set, `hs_inhibit` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Power-on reset, active low |
| cyc_start | input | 1 | One-clock strobe at each switching cycle start |
| ilim_det | input | 1 | Current-limit comparator |
| fb_uv | input | 1 | Feedback below under-voltage threshold |
| fb_ov | input | 1 | Feedback above 115% of reference |
| hs_fault | input | 1 | High-side switch fault |
| ss_low | input | 1 | Soft-start still below 1.5 V |
| out_lt_0p5 | input | 1 | Output below 0.5 V |
| out_gt_0p8 | input | 1 | Output above 0.8 V |
| out_gt_1v0 | input | 1 | Output above 1 V |
| fb_lt_100m | input | 1 | Feedback below 100 mV |
| en | input | 1 | Converter enable |
| hs_inhibit | output | 1 | Suppress the high-side pulse |
| ls_force | output | 1 | Force the low-side switch on |
| dis_load | output | 1 | Switch in the discharge load |
| fault_latched | output | 1 | Fault latch state |

## Verification
The overcurrent window and the fault latch can both act on the same cycle-start clock. A recurrence in the trip window starts the latch on the same edge where the skip window would otherwise advance, so `hs_inhibit` must stay high without a one-clock gap. Recurrences are placed at several window positions and at the first cycle after the window closes, where a fresh skip must start instead of a trip. A behavioural model in the bench predicts all four outputs on every clock, and any one-clock gap or early trip shows up as a mismatch.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

   typedef struct packed {
      logic oc;
      logic uv;
      logic ov;
      logic hs;
      logic sfb;
   } bfs_trip_t;

   function automatic logic bfs_any_trip(input bfs_trip_t t);
      return t.oc | t.uv | t.ov | t.hs | t.sfb;
   endfunction

endpackage

// File: rtl/bfs_ocp_skip.sv
module bfs_ocp_skip #(
   parameter int SKIP_CYCLES   = 8,
   parameter int WINDOW_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cyc_start,
   input  logic ilim_det,
   input  logic arm,
   output logic skip,
   output logic trip
);
   localparam int LAST = SKIP_CYCLES + WINDOW_CYCLES;
   localparam int IW   = $clog2(LAST + 1);

   logic          active;
   logic [IW-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (cyc_start) begin
         if (!active) begin
            if (ilim_det) begin
               active <= 1'b1;
               idx    <= '0;
            end
         end else if (idx == IW'(LAST)) begin
            if (ilim_det) idx <= '0;
            else          active <= 1'b0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign skip = active && (idx <= IW'(SKIP_CYCLES));
   assign trip = cyc_start && active && arm && ilim_det &&
                 (idx >= IW'(SKIP_CYCLES)) && (idx < IW'(LAST));

   a_r1_skip_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !active && ilim_det && !clr) |=> skip)
      else $error("R1 skip window did not open");

endmodule

// File: rtl/bfs_persist.sv
module bfs_persist #(
   parameter int COUNT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic level,
   output logic trip
);
   localparam int CW = $clog2(COUNT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)                      cnt <= '0;
      else if (!level)                        cnt <= '0;
      else if (tick && cnt < CW'(COUNT - 1))  cnt <= cnt + 1'b1;
   end

   assign trip = level && tick && (cnt == CW'(COUNT - 1));

   a_r3_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !level |=> (cnt == '0))
      else $error("R3 persistence count did not restart");

endmodule

// File: rtl/bfs_discharge.sv
module bfs_discharge (
   input  logic clk,
   input  logic rst_n,
   input  logic latched,
   input  logic below_lo,
   input  logic above_hi,
   output logic ls_force
);
   logic ls_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        ls_q <= 1'b1;
      else if (!latched) ls_q <= 1'b1;
      else if (below_lo) ls_q <= 1'b0;
      else if (above_hi) ls_q <= 1'b1;
   end

   assign ls_force = latched && ls_q;

   a_r7_release_low: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && below_lo) |=> !ls_force)
      else $error("R7 low-side not released below lower threshold");

   a_r7_only_latched: assert property (@(posedge clk) disable iff (!rst_n)
      ls_force |-> latched)
      else $error("R7 low-side forced without fault");

endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
   import bfs_pkg::*;
#(
   parameter int SKIP_CYCLES     = 8,
   parameter int WINDOW_CYCLES   = 8,
   parameter int UV_CLKS         = 500,
   parameter int OV_CYCLES       = 16,
   parameter bit SHORT_FB_DETECT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic ilim_det,
   input  logic fb_uv,
   input  logic fb_ov,
   input  logic hs_fault,
   input  logic ss_low,
   input  logic out_lt_0p5,
   input  logic out_gt_0p8,
   input  logic out_gt_1v0,
   input  logic fb_lt_100m,
   input  logic en,
   output logic hs_inhibit,
   output logic ls_force,
   output logic dis_load,
   output logic fault_latched
);
   generate
      if (SKIP_CYCLES < 1 || WINDOW_CYCLES < 1) begin : g_bad_ocp
         $error("skip and window lengths must be at least one cycle");
      end
      if (UV_CLKS < 2 || OV_CYCLES < 2) begin : g_bad_filter
         $error("fault filters need a length of at least two");
      end
   endgenerate

   bfs_trip_t trips;
   logic      fault_q;
   logic      skip;
   logic      clr;

   assign clr = !en;

   bfs_ocp_skip #(
      .SKIP_CYCLES  (SKIP_CYCLES),
      .WINDOW_CYCLES(WINDOW_CYCLES)
   ) u_ocp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .cyc_start(cyc_start),
      .ilim_det (ilim_det),
      .arm      (!ss_low),
      .skip     (skip),
      .trip     (trips.oc)
   );

   bfs_persist #(.COUNT(UV_CLKS)) u_uv (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .tick (1'b1),
      .level(fb_uv && !ss_low),
      .trip (trips.uv)
   );

   bfs_persist #(.COUNT(OV_CYCLES)) u_ov (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .tick (cyc_start),
      .level(fb_ov),
      .trip (trips.ov)
   );

   assign trips.hs = hs_fault;

   generate
      if (SHORT_FB_DETECT) begin : g_sfb_on
         assign trips.sfb = out_gt_1v0 && fb_lt_100m;
      end else begin : g_sfb_off
         assign trips.sfb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                   fault_q <= 1'b0;
      else if (!en)                 fault_q <= 1'b0;
      else if (bfs_any_trip(trips)) fault_q <= 1'b1;
   end

   bfs_discharge u_dis (
      .clk     (clk),
      .rst_n   (rst_n),
      .latched (fault_q),
      .below_lo(out_lt_0p5),
      .above_hi(out_gt_0p8),
      .ls_force(ls_force)
   );

   assign hs_inhibit    = skip || fault_q;
   assign dis_load      = fault_q || !en;
   assign fault_latched = fault_q;

   a_r2_window_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (trips.oc && en) |=> fault_latched)
      else $error("R2 recurrence did not latch");

   a_r9_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !fault_latched)
      else $error("R9 latch survived enable low");

   a_r10_inhibit_held: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched |-> hs_inhibit)
      else $error("R10 high side not inhibited while latched");

   a_r6_hs_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_fault && en) |=> fault_latched)
      else $error("R6 high-side fault did not latch");

endmodule

// File: tb/buck_fault_supervisor_bench.sv
module buck_fault_supervisor_bench;
   localparam int UVN = 500;
   localparam int OVN = 16;
   localparam int CP  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_start = 0, ilim_det = 0, fb_uv = 0, fb_ov = 0, hs_fault = 0;
   logic ss_low = 0, out_lt_0p5 = 0, out_gt_0p8 = 0, out_gt_1v0 = 0;
   logic fb_lt_100m = 0, en = 1;
   logic hs_inhibit, ls_force, dis_load, fault_latched;

   int tests = 0;
   int fails = 0;
   int wd = 0;
   bit done = 0;

   always #2 clk = ~clk;

   buck_fault_supervisor u_buck_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ilim_det(ilim_det),
      .fb_uv(fb_uv), .fb_ov(fb_ov), .hs_fault(hs_fault), .ss_low(ss_low),
      .out_lt_0p5(out_lt_0p5), .out_gt_0p8(out_gt_0p8), .out_gt_1v0(out_gt_1v0),
      .fb_lt_100m(fb_lt_100m), .en(en), .hs_inhibit(hs_inhibit),
      .ls_force(ls_force), .dis_load(dis_load), .fault_latched(fault_latched)
   );

   // behavioural reference: skip state as "cycles since event", filters as run lengths
   bit m_fault = 0, m_ls = 1, m_open = 0;
   int m_age = 0, m_uvrun = 0, m_ovrun = 0;

   always @(posedge clk) begin
      bit trip;
      if (!rst_n) begin
         m_fault = 0; m_ls = 1; m_open = 0; m_age = 0; m_uvrun = 0; m_ovrun = 0;
      end else begin
         trip = 0;
         if (en) begin
            if (cyc_start && m_open && !ss_low && ilim_det && (m_age + 1 >= 9) && (m_age + 1 <= 16)) trip = 1;
            if (fb_uv && !ss_low && (m_uvrun + 1 >= UVN)) trip = 1;
            if (fb_ov && cyc_start && (m_ovrun + 1 >= OVN)) trip = 1;
            if (hs_fault || (out_gt_1v0 && fb_lt_100m)) trip = 1;
         end
         if (!m_fault) m_ls = 1;
         else if (out_lt_0p5) m_ls = 0;
         else if (out_gt_0p8) m_ls = 1;
         if (!en) begin
            m_open = 0; m_age = 0; m_uvrun = 0; m_ovrun = 0;
         end else begin
            if (cyc_start) begin
               if (!m_open) begin
                  if (ilim_det) begin m_open = 1; m_age = 0; end
               end else if (m_age + 1 > 16) begin
                  if (ilim_det) m_age = 0; else m_open = 0;
               end else m_age = m_age + 1;
            end
            if (fb_uv && !ss_low) m_uvrun = m_uvrun + 1; else m_uvrun = 0;
            if (!fb_ov) m_ovrun = 0; else if (cyc_start) m_ovrun = m_ovrun + 1;
         end
         m_fault = en && (m_fault || trip);
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         #1;
         chk("R1,R10 hs_inhibit", hs_inhibit, (m_open && m_age <= 8) || m_fault);
         chk("R7 ls_force", ls_force, m_fault && m_ls);
         chk("R8 dis_load", dis_load, m_fault || !en);
         chk("R2,R9 fault_latched", fault_latched, m_fault);
      end
   end

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   task automatic run_cycle(input bit il);
      ilim_det = il; cyc_start = 1;
      @(negedge clk);
      cyc_start = 0; ilim_det = 0;
      repeat (CP - 1) @(negedge clk);
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) run_cycle(0);
   endtask

   task automatic toggle_en;
      en = 0; @(negedge clk); en = 1; @(negedge clk);
   endtask

   task automatic see(input string tag, input logic act, input logic exp);
      #1 chk(tag, act, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      see("R9 reset fault", fault_latched, 0);
      chk("R9 reset ls", ls_force, 0);
      chk("R9 reset inhibit", hs_inhibit, 0);
      chk("R9 reset dis", dis_load, 0);
      @(negedge clk);

      // R1/R2 single event, no recurrence
      run_cycle(1);
      see("R1 skip on detect", hs_inhibit, 1);
      idle_cycles(8);
      see("R1 still skipping in cycle 8", hs_inhibit, 1);
      run_cycle(0);
      see("R1 resumes in cycle 9", hs_inhibit, 0);
      idle_cycles(8);
      see("R2 no recurrence no fault", fault_latched, 0);
      see("R2 window closed", hs_inhibit, 0);

      // R2 event right after window: fresh skip, no trip
      run_cycle(1); idle_cycles(16); run_cycle(1);
      see("R2 post-window restart no fault", fault_latched, 0);
      see("R1 post-window restart skips", hs_inhibit, 1);
      idle_cycles(17);

      // R2 recurrence in cycle 12
      run_cycle(1); idle_cycles(11); run_cycle(1);
      see("R2 recurrence latches", fault_latched, 1);
      see("R10 inhibit while latched", hs_inhibit, 1);
      see("R8 load while latched", dis_load, 1);
      see("R7 low-side on entry", ls_force, 1);
      out_lt_0p5 = 1; @(negedge clk); out_lt_0p5 = 0;
      see("R7 released below 0.5", ls_force, 0);
      repeat (3) @(negedge clk);
      see("R7 stays released between thresholds", ls_force, 0);
      out_gt_0p8 = 1; @(negedge clk); out_gt_0p8 = 0;
      see("R7 re-forced above 0.8", ls_force, 1);
      en = 0; @(negedge clk);
      see("R9 enable low clears", fault_latched, 0);
      see("R8 load while disabled", dis_load, 1);
      en = 1; @(negedge clk);
      see("R8 load off when enabled", dis_load, 0);

      // R2 recurrence at the first window cycle (9)
      run_cycle(1); idle_cycles(8); run_cycle(1);
      see("R2 recurrence cycle 9 latches", fault_latched, 1);
      toggle_en();

      // R5 soft-start blocks overcurrent and under-voltage
      ss_low = 1;
      run_cycle(1); idle_cycles(10); run_cycle(1);
      see("R5 overcurrent blocked in soft-start", fault_latched, 0);
      idle_cycles(17);
      fb_uv = 1; repeat (600) @(negedge clk); fb_uv = 0;
      see("R5 under-voltage blocked in soft-start", fault_latched, 0);

      // R6 / R4 over-voltage in soft-start
      fb_ov = 1; idle_cycles(16); fb_ov = 0;
      see("R4,R6 over-voltage latches in soft-start", fault_latched, 1);
      toggle_en();
      hs_fault = 1; @(negedge clk); hs_fault = 0;
      see("R6 high-side fault in soft-start", fault_latched, 1);
      toggle_en();
      out_gt_1v0 = 1; fb_lt_100m = 1; @(negedge clk); out_gt_1v0 = 0; fb_lt_100m = 0;
      see("R6 shorted feedback in soft-start", fault_latched, 1);
      toggle_en();
      out_gt_1v0 = 1; @(negedge clk); out_gt_1v0 = 0;
      see("R6 output high alone no fault", fault_latched, 0);
      ss_low = 0;

      // R3 under-voltage filter
      fb_uv = 1; repeat (UVN - 1) @(negedge clk); fb_uv = 0;
      see("R3 499 clocks no fault", fault_latched, 0);
      @(negedge clk);
      fb_uv = 1; repeat (UVN) @(negedge clk); fb_uv = 0;
      see("R3 500 clocks latches", fault_latched, 1);
      toggle_en();

      // R4 over-voltage short of count
      fb_ov = 1; idle_cycles(OVN - 1); fb_ov = 0;
      see("R4 15 cycles no fault", fault_latched, 0);
      @(negedge clk);

      // R9 reset clears latch
      hs_fault = 1; @(negedge clk); hs_fault = 0;
      see("R9 latched before reset", fault_latched, 1);
      rst_n = 0; @(negedge clk);
      see("R9 reset clears latch", fault_latched, 0);
      rst_n = 1; @(negedge clk);

      done = 1;
      summary();
      $finish;
   end
endmodule